// File: doc/BRIEF.md
# RS-485 Transceiver Enable Controller

This block sits beside a UART and produces the driver-enable and receiver-enable levels for an RS-485 line transceiver. Software supplies a control word and two separate enable bits, one for the driver and one for the receiver. The UART supplies three status lines: data waiting to be sent, a receive frame in progress, and an empty transmit shift register. The block combines these into two pin levels. Each pin has its own programmable active level.

The control word enables the function and selects one of three arbitration schemes. In full duplex, both enables may be active together. In software-exclusive mode, the two enable bits are honoured but only one output may be active at a time. In hardware-exclusive mode, the block itself turns the driver on for a transmission and gives the line back to the receiver once the shifter has drained.

A receive frame already in progress is never cut short when software withdraws the receiver enable. The only exception is when an exclusive mode needs the line for the driver.

Top module: `rs485_xcvr_en`

## Requirements
- R1: When the enable bit (ctrl_i bit 0) is 0, both pins show their inactive level one clock later. The hardware-exclusive sequencer also returns to its listening phase.
- R2: A pin is active when its level equals its polarity bit: ctrl_i bit 1 for the receiver pin and ctrl_i bit 2 for the driver pin. A polarity change is visible on the pin in the same cycle.
- R3: Mode 0 (ctrl_i bits 4:3 = 0) makes the driver follow de_en_i and the receiver follow re_en_i independently, so both may be active at once.
- R4: Mode 1 makes the driver follow de_en_i and the receiver follow re_en_i. When both enables are set, only the driver is active.
- R5: In mode 2, tx_pend_i with de_en_i set makes the driver active and the receiver inactive on the next clock edge.
- R6: In mode 2, the driver stays active until tx_empty_i is high with tx_pend_i low. On the following edge the driver goes inactive and the receiver follows re_en_i again.
- R7: Mode value 3 behaves exactly as mode 2.
- R8: If the receiver is active and rx_busy_i is high, clearing re_en_i keeps the receiver active until rx_busy_i falls. It goes inactive on the edge after that.
- R9: In modes 1 to 3, an active driver request overrides the receive hold of R8, so the receiver goes inactive at once.
- R10: Both enable levels are registered, giving a one-cycle latency from de_en_i/re_en_i/status to the pins. Reset places both pins at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 5 | Control word: bit0 enable, bit1 RE polarity, bit2 DE polarity, bits4:3 transfer mode |
| de_en_i | input | 1 | Driver enable bit |
| re_en_i | input | 1 | Receiver enable bit |
| tx_pend_i | input | 1 | Transmit data waiting in the UART |
| rx_busy_i | input | 1 | A receive frame is in progress |
| tx_empty_i | input | 1 | Transmit shift register empty |
| de_o | output | 1 | Driver-enable pin level |
| re_o | output | 1 | Receiver-enable pin level |

## Verification
The properties assume the control word and status lines are steady around each rising edge. They compare the pin levels with the current polarity bits, so they also rely on polarity not changing between a stimulus and the edge that follows it. The stimulus changes every input only on the falling edge and holds the polarity bits steady across each checked step. It drives tx_empty_i low whenever tx_pend_i is high, as a real transmitter would.

// File: rtl/rs485_en_pkg.sv
package rs485_en_pkg;
  localparam int CtrlW     = 5;
  localparam int CtrlEn    = 0;
  localparam int CtrlRePol = 1;
  localparam int CtrlDePol = 2;
  localparam int ModeLsb   = 3;
  localparam int ModeW     = 2;
  localparam int ModeMsb   = ModeLsb + ModeW - 1;

  typedef enum logic [ModeW-1:0] {
    XM_DUPLEX  = 2'd0,
    XM_SW_EXCL = 2'd1,
    XM_HW_EXCL = 2'd2,
    XM_RSVD    = 2'd3
  } xfer_mode_e;

  typedef enum logic {
    PH_LISTEN = 1'b0,
    PH_TALK   = 1'b1
  } hw_phase_e;
endpackage

// File: rtl/rs485_hw_seq.sv
module rs485_hw_seq
  import rs485_en_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      de_en_i,
  input  logic      tx_pend_i,
  input  logic      tx_empty_i,
  output hw_phase_e phase_d_o
);
  hw_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!run_i) begin
      phase_d = PH_LISTEN;
    end else begin
      unique case (phase_q)
        PH_LISTEN: if (tx_pend_i && de_en_i) phase_d = PH_TALK;
        PH_TALK:   if (!de_en_i || (tx_empty_i && !tx_pend_i)) phase_d = PH_LISTEN;
        default:   phase_d = PH_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_LISTEN;
    else         phase_q <= phase_d;
  end

  assign phase_d_o = phase_d;
endmodule

// File: rtl/rs485_mode_arb.sv
module rs485_mode_arb
  import rs485_en_pkg::*;
(
  input  xfer_mode_e mode_i,
  input  hw_phase_e  phase_i,
  input  logic       de_en_i,
  input  logic       re_en_i,
  output logic       de_req_o,
  output logic       re_req_o,
  output logic       excl_o
);
  always_comb begin
    de_req_o = 1'b0;
    re_req_o = 1'b0;
    excl_o   = 1'b1;
    unique case (mode_i)
      XM_DUPLEX: begin
        de_req_o = de_en_i;
        re_req_o = re_en_i;
        excl_o   = 1'b0;
      end
      XM_SW_EXCL: begin
        de_req_o = de_en_i;
        re_req_o = re_en_i && !de_en_i;
      end
      default: begin
        // reserved code shares the hardware-exclusive path
        de_req_o = (phase_i == PH_TALK);
        re_req_o = (phase_i == PH_LISTEN) && re_en_i;
      end
    endcase
  end
endmodule

// File: rtl/rs485_pin_stage.sv
module rs485_pin_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic de_req_i,
  input  logic re_req_i,
  input  logic excl_i,
  input  logic rx_busy_i,
  input  logic de_pol_i,
  input  logic re_pol_i,
  output logic de_o,
  output logic re_o
);
  logic de_q, re_q, de_d, re_d, hold;

  // keep RE through an unfinished frame unless an exclusive mode hands the line to DE
  assign hold = re_q && rx_busy_i && !(excl_i && de_req_i);
  assign de_d = run_i && de_req_i;
  assign re_d = run_i && (re_req_i || hold);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      re_q <= 1'b0;
    end else begin
      de_q <= de_d;
      re_q <= re_d;
    end
  end

  assign de_o = de_q ? de_pol_i : !de_pol_i;
  assign re_o = re_q ? re_pol_i : !re_pol_i;
endmodule

// File: rtl/rs485_xcvr_en.sv
module rs485_xcvr_en
  import rs485_en_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CtrlW-1:0] ctrl_i,
  input  logic             de_en_i,
  input  logic             re_en_i,
  input  logic             tx_pend_i,
  input  logic             rx_busy_i,
  input  logic             tx_empty_i,
  output logic             de_o,
  output logic             re_o
);
  xfer_mode_e mode;
  hw_phase_e  phase_d;
  logic       run, hw_run, de_req, re_req, excl;

  assign run    = ctrl_i[CtrlEn];
  assign mode   = xfer_mode_e'(ctrl_i[ModeMsb:ModeLsb]);
  assign hw_run = run && ctrl_i[ModeMsb];

  rs485_hw_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (hw_run),
    .de_en_i   (de_en_i),
    .tx_pend_i (tx_pend_i),
    .tx_empty_i(tx_empty_i),
    .phase_d_o (phase_d)
  );

  rs485_mode_arb u_arb (
    .mode_i  (mode),
    .phase_i (phase_d),
    .de_en_i (de_en_i),
    .re_en_i (re_en_i),
    .de_req_o(de_req),
    .re_req_o(re_req),
    .excl_o  (excl)
  );

  rs485_pin_stage u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .de_req_i (de_req),
    .re_req_i (re_req),
    .excl_i   (excl),
    .rx_busy_i(rx_busy_i),
    .de_pol_i (ctrl_i[CtrlDePol]),
    .re_pol_i (ctrl_i[CtrlRePol]),
    .de_o     (de_o),
    .re_o     (re_o)
  );
endmodule

// File: rtl/rs485_xcvr_en_chk.sv
module rs485_xcvr_en_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] ctrl_i,
  input logic       de_en_i,
  input logic       re_en_i,
  input logic       tx_pend_i,
  input logic       rx_busy_i,
  input logic       de_o,
  input logic       re_o
);
  logic de_act, re_act;
  assign de_act = (de_o == ctrl_i[2]);
  assign re_act = (re_o == ctrl_i[1]);

  assert_off_when_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[0] |=> (!de_act && !re_act));

  assert_duplex_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[4:3] == 2'd0 && de_en_i && re_en_i) |=> (de_act && re_act));

  assert_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[4:3] != 2'd0) |=> !(de_act && re_act));

  assert_sw_de_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[4:3] == 2'd1 && de_en_i) |=> de_act);

  assert_hw_talk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[4] && tx_pend_i && de_en_i) |=> (de_act && !re_act));

  assert_rx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && ctrl_i[4:3] == 2'd0 && re_act && rx_busy_i) |=> re_act);
endmodule

bind rs485_xcvr_en rs485_xcvr_en_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ctrl_i   (ctrl_i),
  .de_en_i  (de_en_i),
  .re_en_i  (re_en_i),
  .tx_pend_i(tx_pend_i),
  .rx_busy_i(rx_busy_i),
  .de_o     (de_o),
  .re_o     (re_o)
);

// File: tb/rs485_xcvr_en_tb.sv
module rs485_xcvr_en_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] ctrl_i = 5'd0;
  logic       de_en_i = 1'b0, re_en_i = 1'b0;
  logic       tx_pend_i = 1'b0, rx_busy_i = 1'b0, tx_empty_i = 1'b1;
  logic       de_o, re_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_i = ~clk_i;

  rs485_xcvr_en u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
    .de_en_i(de_en_i), .re_en_i(re_en_i), .tx_pend_i(tx_pend_i),
    .rx_busy_i(rx_busy_i), .tx_empty_i(tx_empty_i),
    .de_o(de_o), .re_o(re_o)
  );

  function automatic logic [4:0] mk_ctrl(logic en, logic re_pol, logic de_pol, logic [1:0] mode);
    return {mode, de_pol, re_pol, en};
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: de/re got %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: compares pins one delta after each edge against queued expectations
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), {de_o, re_o}, exp_q.pop_front());
  end

  // driver: apply inputs on the falling edge, queue expected pin levels (R2 mapping)
  task automatic step(logic [4:0] c, logic de_en, logic re_en, logic pend, logic busy,
                      logic empty, logic exp_de, logic exp_re, string tag);
    @(negedge clk_i);
    ctrl_i = c; de_en_i = de_en; re_en_i = re_en;
    tx_pend_i = pend; rx_busy_i = busy; tx_empty_i = empty;
    exp_q.push_back({exp_de ? c[2] : ~c[2], exp_re ? c[1] : ~c[1]});
    tag_q.push_back(tag);
  endtask

  initial begin
    logic [4:0] m0, m1, m2, m3, off;
    m0 = mk_ctrl(1, 0, 1, 2'd0);
    m1 = mk_ctrl(1, 0, 1, 2'd1);
    m2 = mk_ctrl(1, 0, 1, 2'd2);
    m3 = mk_ctrl(1, 0, 1, 2'd3);
    off = mk_ctrl(0, 0, 1, 2'd0);

    // R10: reset state, ctrl=0 means both active-low, so inactive pins read 1
    #23;
    check("R10 reset", {de_o, re_o}, 2'b11);
    @(negedge clk_i); rst_ni = 1'b1;

    step(off, 1, 1, 0, 0, 1, 0, 0, "R1 disabled");
    step(m0, 1, 1, 0, 0, 1, 1, 1, "R3 duplex both");
    step(m0, 0, 1, 0, 0, 1, 0, 1, "R3 duplex re only");
    step(mk_ctrl(1, 1, 0, 2'd0), 0, 1, 0, 0, 1, 0, 1, "R2 swapped polarity");
    step(m1, 1, 1, 0, 0, 1, 1, 0, "R4 de priority");
    step(m1, 0, 1, 0, 0, 1, 0, 1, "R4 re alone");
    step(m0, 0, 1, 0, 1, 1, 0, 1, "R8 receiving");
    step(m0, 0, 0, 0, 1, 1, 0, 1, "R8 hold 1");
    step(m0, 0, 0, 0, 1, 1, 0, 1, "R8 hold 2");
    step(m0, 0, 0, 0, 0, 1, 0, 0, "R8 release");
    step(m1, 0, 1, 0, 1, 1, 0, 1, "R9 receiving");
    step(m1, 1, 0, 0, 1, 1, 1, 0, "R9 de preempts hold");
    step(m2, 1, 1, 0, 0, 1, 0, 1, "R5 listen");
    step(m2, 1, 1, 1, 0, 0, 1, 0, "R5 talk");
    step(m2, 1, 1, 0, 0, 0, 1, 0, "R6 draining");
    step(m2, 1, 1, 0, 0, 1, 0, 1, "R6 restored");
    step(m3, 1, 1, 1, 0, 0, 1, 0, "R7 talk");
    step(m3, 1, 1, 0, 0, 1, 0, 1, "R7 restored");
    step(m2, 1, 1, 1, 0, 0, 1, 0, "R1 pre talk");
    step(mk_ctrl(0, 0, 1, 2'd2), 1, 1, 0, 0, 0, 0, 0, "R1 drop mid talk");
    step(m2, 1, 1, 0, 0, 1, 0, 1, "R1 back in listen");
    step(m0, 0, 0, 0, 0, 1, 0, 0, "R10 idle");
    @(posedge clk_i); #2;

    // R10: input change before the edge must not reach the pins
    @(negedge clk_i);
    de_en_i = 1'b1;
    #1;
    check("R10 latency before edge", {de_o, re_o}, 2'b01);
    @(posedge clk_i); #2;
    check("R10 latency after edge", {de_o, re_o}, 2'b11);

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule